// File: doc/BRIEF.md
# Reset self-test and console controller

After every reset this block runs a fixed power-up self-test and then decides how the processor starts. First it runs a stuck-at pattern test over a small bank of internal registers and the two timer registers. Then it adds up every word of a small emulation ROM held inside the block, modulo 2^16, and compares the result with an expected checksum given on an input. When both phases are over, it loads a fault code, drives a fault discrete, and either enters console mode, starts execution at a fixed vector, or holds execution off for good.

A console request pin is captured while reset is held. If the pin was high, the controller stops in console mode after the tests. Console mode ends on a continue command, whose 2-bit argument picks which timers run, or on a run command that supplies a start address. A failure in either of the two critical registers, the interrupt-pending register and the fault register, stops execution from ever starting. For test purposes, a stuck bit can be overlaid on the readback of any one target through the injection inputs.

Top module: `bist_console_ctrl`

## Requirements
- R1: While reset is held, every output is 0. After reset is released the tests start by themselves. `test_done` is a single-cycle pulse, first seen 4*(NUM_REGS+2)+ROM_DEPTH+1 clock edges after the first edge with reset released. Execution and console mode stay off until that pulse.
- R2: Each target gets 0x0000 and then 0xFFFF written to it, with a readback after each write. Targets 0 and 1 are the interrupt-pending and fault registers, 2 to NUM_REGS-1 are general registers, NUM_REGS is timer A and NUM_REGS+1 is timer B. With `inj_en` high, readback of target `inj_idx` has bit `inj_bit` forced to `inj_val`.
- R3: Any readback that differs from the value written loads `fault_code` with 0x5.
- R4: ROM word i is ((i*0x9E37) mod 2^16) XOR 0x5A5A for i = 0 to ROM_DEPTH-1. If the modulo-2^16 sum of all words differs from `rom_exp_sum`, `fault_code` is 0x6.
- R5: With no failure `fault_code` is 0x0. If both kinds of failure occur, the code is 0x5.
- R6: `fault_discrete` is 1 exactly when `fault_code` is not zero, from the done pulse onward. Both hold their values until the next reset.
- R7: If `console_pin` was high during reset, `console_mode` goes to 1 with the done pulse. `exec_run`, `timer_a_en` and `timer_b_en` stay 0 while console mode is active.
- R8: If the failing target is 0 or 1, `exec_blocked` is 1 from the done pulse. `exec_run` never rises, and console commands are ignored.
- R9: Without a console request and with no critical failure, the done edge sets `exec_run`, pulses `start_strobe` for one cycle, sets `start_addr` to RESET_VEC (default 0x0040) and enables both timers.
- R10: `cmd_continue` in console mode clears console mode and sets `exec_run` without a start strobe. `cmd_arg` bit 0 enables timer A and bit 1 enables timer B: 0 runs none, 1 runs A, 2 runs B, 3 runs both.
- R11: `cmd_run` in console mode loads `start_addr` from `cmd_addr`, pulses `start_strobe` for one cycle, enables both timers and sets `exec_run`. It takes priority over a `cmd_continue` in the same cycle.
- R12: Commands outside console mode have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| console_pin | input | 1 | Console request, captured while reset is held |
| inj_en | input | 1 | Enable the stuck-bit overlay |
| inj_idx | input | IDX_W | Target index that gets the overlay |
| inj_bit | input | 4 | Bit position forced in the overlay |
| inj_val | input | 1 | Value the stuck bit is forced to |
| rom_exp_sum | input | 16 | Expected ROM checksum |
| cmd_continue | input | 1 | Continue command (console mode) |
| cmd_arg | input | 2 | Timer selection for continue |
| cmd_run | input | 1 | Run-from-address command (console mode) |
| cmd_addr | input | 16 | Start address for run |
| test_done | output | 1 | One-cycle end-of-test pulse |
| fault_code | output | 4 | Self-test result code |
| fault_discrete | output | 1 | High on any self-test failure |
| console_mode | output | 1 | Console mode active |
| exec_run | output | 1 | Program execution enabled |
| exec_blocked | output | 1 | Execution barred by a critical failure |
| timer_a_en | output | 1 | Timer A enable |
| timer_b_en | output | 1 | Timer B enable |
| start_strobe | output | 1 | One-cycle start-address strobe |
| start_addr | output | 16 | Start address |

## Verification
Several rules are checked on every cycle: the done pulse lasts one cycle, the fault code takes only the three legal values and follows the register failure flag, the discrete agrees with the code, the code stays fixed after the test, no execution happens in console mode or after a critical failure, and the start strobe is a single-cycle pulse that comes with execution. Other behaviour depends on a particular scenario, so only the bench can show it: the exact test latency, which target and which polarity of stuck bit gets caught, whether the checksum compare is correct, how each continue argument maps to the timers, and that commands are ignored outside console mode.

// File: rtl/bist_pkg.sv
package bist_pkg;
  localparam int DW     = 16;
  localparam int BIT_W  = 4;
  localparam int CRIT_N = 2;

  localparam logic [3:0] FC_PASS = 4'h0;
  localparam logic [3:0] FC_REG  = 4'h5;
  localparam logic [3:0] FC_ROM  = 4'h6;

  typedef enum logic [1:0] {SQ_REG, SQ_ROM, SQ_CMP, SQ_END} seq_st_e;

  // Content of one ROM location: low half of addr*mul, then xor.
  function automatic logic [DW-1:0] rom_word(input logic [DW-1:0] addr,
                                             input logic [DW-1:0] mul,
                                             input logic [DW-1:0] xr);
    logic [2*DW-1:0] prod;
    prod = addr * mul;
    return prod[DW-1:0] ^ xr;
  endfunction

  // Readback with one bit forced to a stuck value.
  function automatic logic [DW-1:0] stuck_apply(input logic [DW-1:0] d,
                                                input logic [BIT_W-1:0] b,
                                                input logic v);
    logic [DW-1:0] m;
    m = DW'(1) << b;
    return v ? (d | m) : (d & ~m);
  endfunction

  function automatic logic [3:0] pick_code(input logic reg_bad, input logic rom_bad);
    if (reg_bad) return FC_REG;
    if (rom_bad) return FC_ROM;
    return FC_PASS;
  endfunction
endpackage

// File: rtl/bist_reg_bank.sv
module bist_reg_bank
  import bist_pkg::*;
#(
  parameter int NUM_TGT = 8,
  parameter int IDX_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             inj_en,
  input  logic [IDX_W-1:0] inj_idx,
  input  logic [BIT_W-1:0] inj_bit,
  input  logic             inj_val,
  output logic [DW-1:0]    rd_data
);
  logic [NUM_TGT-1:0][DW-1:0] bank_q;
  logic [DW-1:0] raw;

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_tgt
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                q <= '0;
      else if (wr_en && wr_idx == IDX_W'(g))     q <= wr_data;
    end
    assign bank_q[g] = q;
  end

  always_comb begin
    raw = '0;
    for (int i = 0; i < NUM_TGT; i++)
      if (rd_idx == IDX_W'(i)) raw = bank_q[i];
  end

  assign rd_data = (inj_en && inj_idx == rd_idx) ? stuck_apply(raw, inj_bit, inj_val) : raw;
endmodule

// File: rtl/bist_rom_sum.sv
module bist_rom_sum
  import bist_pkg::*;
#(
  parameter int          DEPTH = 32,
  parameter logic [15:0] MUL   = 16'h9E37,
  parameter logic [15:0] XR    = 16'h5A5A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic          rom_last,
  output logic [DW-1:0] sum
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0] addr;

  assign rom_last = (addr == AW'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
      sum  <= '0;
    end else if (run) begin
      sum  <= sum + rom_word(DW'(addr), MUL, XR);
      addr <= rom_last ? '0 : addr + AW'(1);
    end
  end
endmodule

// File: rtl/bist_seq.sv
module bist_seq
  import bist_pkg::*;
#(
  parameter int NUM_TGT = 8,
  parameter int IDX_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    rd_data,
  input  logic             rom_last,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [DW-1:0]    wr_data,
  output logic [IDX_W-1:0] rd_idx,
  output logic             rom_run,
  output logic             reg_fail,
  output logic             crit_fail,
  output logic             seq_cmp
);
  seq_st_e          st;
  logic [IDX_W-1:0] idx;
  logic [1:0]       ph;
  logic [DW-1:0]    pattern;
  logic             check_now;
  logic             mismatch;
  logic             last_tgt;

  // ph: 0 write zeros, 1 read zeros, 2 write ones, 3 read ones
  assign pattern   = {DW{ph[1]}};
  assign wr_en     = (st == SQ_REG) && !ph[0];
  assign wr_idx    = idx;
  assign wr_data   = pattern;
  assign rd_idx    = idx;
  assign check_now = (st == SQ_REG) && ph[0];
  assign mismatch  = check_now && (rd_data != pattern);
  assign last_tgt  = (idx == IDX_W'(NUM_TGT - 1));
  assign rom_run   = (st == SQ_ROM);
  assign seq_cmp   = (st == SQ_CMP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= SQ_REG;
      idx       <= '0;
      ph        <= '0;
      reg_fail  <= 1'b0;
      crit_fail <= 1'b0;
    end else begin
      if (mismatch) begin
        reg_fail <= 1'b1;
        if (idx < IDX_W'(CRIT_N)) crit_fail <= 1'b1;
      end
      unique case (st)
        SQ_REG: begin
          ph <= ph + 2'd1;
          if (ph == 2'd3) begin
            if (last_tgt) st <= SQ_ROM;
            else          idx <= idx + IDX_W'(1);
          end
        end
        SQ_ROM:  if (rom_last) st <= SQ_CMP;
        SQ_CMP:  st <= SQ_END;
        default: st <= SQ_END;
      endcase
    end
  end
endmodule

// File: rtl/bist_console_ctrl.sv
module bist_console_ctrl
  import bist_pkg::*;
#(
  parameter int          NUM_REGS  = 6,
  parameter int          ROM_DEPTH = 32,
  parameter logic [15:0] ROM_MUL   = 16'h9E37,
  parameter logic [15:0] ROM_XOR   = 16'h5A5A,
  parameter logic [15:0] RESET_VEC = 16'h0040,
  parameter int          IDX_W     = $clog2(NUM_REGS + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             console_pin,
  input  logic             inj_en,
  input  logic [IDX_W-1:0] inj_idx,
  input  logic [3:0]       inj_bit,
  input  logic             inj_val,
  input  logic [15:0]      rom_exp_sum,
  input  logic             cmd_continue,
  input  logic [1:0]       cmd_arg,
  input  logic             cmd_run,
  input  logic [15:0]      cmd_addr,
  output logic             test_done,
  output logic [3:0]       fault_code,
  output logic             fault_discrete,
  output logic             console_mode,
  output logic             exec_run,
  output logic             exec_blocked,
  output logic             timer_a_en,
  output logic             timer_b_en,
  output logic             start_strobe,
  output logic [15:0]      start_addr
);
  localparam int NUM_TGT = NUM_REGS + 2;

  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [DW-1:0]    wr_data;
  logic [IDX_W-1:0] rd_idx;
  logic [DW-1:0]    rd_data;
  logic             rom_run;
  logic             rom_last;
  logic [DW-1:0]    rom_sum;
  logic             reg_fail;
  logic             crit_fail;
  logic             seq_cmp;
  logic             finished;
  logic             con_req;
  logic [1:0]       tmr_en;
  logic [3:0]       code_n;

  bist_seq #(.NUM_TGT(NUM_TGT), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .rom_last(rom_last),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx),
    .rom_run(rom_run), .reg_fail(reg_fail), .crit_fail(crit_fail), .seq_cmp(seq_cmp)
  );

  bist_reg_bank #(.NUM_TGT(NUM_TGT), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .inj_en(inj_en), .inj_idx(inj_idx), .inj_bit(inj_bit),
    .inj_val(inj_val), .rd_data(rd_data)
  );

  bist_rom_sum #(.DEPTH(ROM_DEPTH), .MUL(ROM_MUL), .XR(ROM_XOR)) u_rom (
    .clk(clk), .rst_n(rst_n), .run(rom_run), .rom_last(rom_last), .sum(rom_sum)
  );

  assign code_n     = pick_code(reg_fail, rom_sum != rom_exp_sum);
  assign timer_a_en = tmr_en[0];
  assign timer_b_en = tmr_en[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      con_req        <= console_pin;
      finished       <= 1'b0;
      test_done      <= 1'b0;
      fault_code     <= FC_PASS;
      fault_discrete <= 1'b0;
      console_mode   <= 1'b0;
      exec_run       <= 1'b0;
      exec_blocked   <= 1'b0;
      tmr_en         <= 2'b00;
      start_strobe   <= 1'b0;
      start_addr     <= '0;
    end else begin
      test_done    <= 1'b0;
      start_strobe <= 1'b0;
      if (seq_cmp) begin
        finished       <= 1'b1;
        test_done      <= 1'b1;
        fault_code     <= code_n;
        fault_discrete <= (code_n != FC_PASS);
        exec_blocked   <= crit_fail;
        if (con_req) begin
          console_mode <= 1'b1;
        end else if (!crit_fail) begin
          exec_run     <= 1'b1;
          start_strobe <= 1'b1;
          start_addr   <= RESET_VEC;
          tmr_en       <= 2'b11;
        end
      end else if (console_mode && !exec_blocked) begin
        if (cmd_run) begin
          console_mode <= 1'b0;
          exec_run     <= 1'b1;
          start_strobe <= 1'b1;
          start_addr   <= cmd_addr;
          tmr_en       <= 2'b11;
        end else if (cmd_continue) begin
          console_mode <= 1'b0;
          exec_run     <= 1'b1;
          tmr_en       <= cmd_arg;
        end
      end
    end
  end
endmodule

// File: rtl/bist_console_chk.sv
module bist_console_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       test_done,
  input logic [3:0] fault_code,
  input logic       fault_discrete,
  input logic       console_mode,
  input logic       exec_run,
  input logic       timer_a_en,
  input logic       timer_b_en,
  input logic       start_strobe,
  input logic       reg_fail,
  input logic       crit_fail,
  input logic       finished
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    test_done |=> !test_done); // R1
  AST_IDLE_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !finished |-> (!exec_run && !console_mode)); // R1
  AST_REG_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (test_done && reg_fail) |-> fault_code == 4'h5); // R3
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    test_done |-> (fault_code == 4'h0 || fault_code == 4'h5 || fault_code == 4'h6)); // R5
  AST_DISCRETE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    finished |-> (fault_discrete == (fault_code != 4'h0))); // R6
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    finished |=> $stable(fault_code)); // R6
  AST_CONSOLE_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    console_mode |-> (!exec_run && !timer_a_en && !timer_b_en)); // R7
  AST_CRIT_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    crit_fail |-> !exec_run); // R8
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    start_strobe |=> !start_strobe); // R9
  AST_STROBE_WITH_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    start_strobe |-> exec_run); // R11
endmodule

bind bist_console_ctrl bist_console_chk u_chk (
  .clk(clk), .rst_n(rst_n), .test_done(test_done), .fault_code(fault_code),
  .fault_discrete(fault_discrete), .console_mode(console_mode), .exec_run(exec_run),
  .timer_a_en(timer_a_en), .timer_b_en(timer_b_en), .start_strobe(start_strobe),
  .reg_fail(reg_fail), .crit_fail(crit_fail), .finished(finished)
);

// File: tb/bist_console_ctrl_bench.sv
module bist_console_ctrl_bench;
  localparam int NREG  = 6;
  localparam int DEPTH = 32;
  localparam logic [15:0] RVEC = 16'h0040;

  typedef struct packed {
    logic       con;
    logic       inj;
    logic [2:0] idx;
    logic [3:0] bitn;
    logic       val;
    logic       sum_ok;
    logic [3:0] code;
    logic       disc;
    logic       cmode;
    logic       run;
    logic       blk;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 3'd0, 4'd0,  1'b0, 1'b1, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{1'b1, 1'b0, 3'd0, 4'd0,  1'b0, 1'b1, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b1, 3'd2, 4'd5,  1'b1, 1'b1, 4'h5, 1'b1, 1'b0, 1'b1, 1'b0},
    '{1'b0, 1'b1, 3'd0, 4'd0,  1'b0, 1'b1, 4'h5, 1'b1, 1'b0, 1'b0, 1'b1},
    '{1'b1, 1'b1, 3'd1, 4'd15, 1'b1, 1'b1, 4'h5, 1'b1, 1'b1, 1'b0, 1'b1},
    '{1'b0, 1'b0, 3'd0, 4'd0,  1'b0, 1'b0, 4'h6, 1'b1, 1'b0, 1'b1, 1'b0},
    '{1'b1, 1'b0, 3'd0, 4'd0,  1'b0, 1'b0, 4'h6, 1'b1, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b1, 3'd7, 4'd3,  1'b0, 1'b0, 4'h5, 1'b1, 1'b0, 1'b1, 1'b0},
    '{1'b0, 1'b1, 3'd6, 4'd9,  1'b1, 1'b1, 4'h5, 1'b1, 1'b0, 1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        console_pin = 1'b0;
  logic        inj_en = 1'b0;
  logic [2:0]  inj_idx = '0;
  logic [3:0]  inj_bit = '0;
  logic        inj_val = 1'b0;
  logic [15:0] rom_exp_sum = '0;
  logic        cmd_continue = 1'b0;
  logic [1:0]  cmd_arg = '0;
  logic        cmd_run = 1'b0;
  logic [15:0] cmd_addr = '0;
  logic        test_done, fault_discrete, console_mode, exec_run, exec_blocked;
  logic        timer_a_en, timer_b_en, start_strobe;
  logic [3:0]  fault_code;
  logic [15:0] start_addr;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] good_sum;
  int lat;

  always #4 clk = ~clk;

  bist_console_ctrl u_bist_console_ctrl (
    .clk(clk), .rst_n(rst_n), .console_pin(console_pin), .inj_en(inj_en),
    .inj_idx(inj_idx), .inj_bit(inj_bit), .inj_val(inj_val), .rom_exp_sum(rom_exp_sum),
    .cmd_continue(cmd_continue), .cmd_arg(cmd_arg), .cmd_run(cmd_run), .cmd_addr(cmd_addr),
    .test_done(test_done), .fault_code(fault_code), .fault_discrete(fault_discrete),
    .console_mode(console_mode), .exec_run(exec_run), .exec_blocked(exec_blocked),
    .timer_a_en(timer_a_en), .timer_b_en(timer_b_en), .start_strobe(start_strobe),
    .start_addr(start_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bench's own checksum: accumulate wide, keep low 16 bits.
  function automatic logic [15:0] expected_sum();
    logic [31:0] acc = 0;
    for (int i = 0; i < DEPTH; i++)
      acc = acc + ((((i * 32'h9E37) % 32'h10000)) ^ 32'h5A5A);
    return acc[15:0];
  endfunction

  // Reset with a given setup; returns negedges counted until done is seen.
  task automatic run_test(input logic con, input logic inj, input logic [2:0] idx,
                          input logic [3:0] b, input logic v, input logic sum_ok,
                          output int waited);
    @(negedge clk);
    rst_n = 1'b0; console_pin = con; inj_en = inj; inj_idx = idx; inj_bit = b;
    inj_val = v; rom_exp_sum = sum_ok ? good_sum : good_sum + 16'd1;
    cmd_continue = 1'b0; cmd_run = 1'b0;
    repeat (3) @(negedge clk);
    console_pin = 1'b0;
    rst_n = 1'b1;
    waited = 0;
    while (waited < 500) begin
      @(negedge clk);
      waited++;
      if (test_done) break;
    end
  endtask

  task automatic send(input logic cont, input logic [1:0] arg, input logic run,
                      input logic [15:0] addr);
    cmd_continue = cont; cmd_arg = arg; cmd_run = run; cmd_addr = addr;
    @(negedge clk);
    cmd_continue = 1'b0; cmd_run = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    good_sum = expected_sum();

    // R1 reset state
    repeat (2) @(negedge clk);
    chk("R1 reset done", test_done, 0);
    chk("R1 reset code", fault_code, 0);
    chk("R1 reset discrete", fault_discrete, 0);
    chk("R1 reset outputs", {console_mode, exec_run, exec_blocked, timer_a_en, timer_b_en, start_strobe}, 0);
    chk("R1 reset start_addr", start_addr, 0);

    // Table of scenarios
    for (int k = 0; k < NV; k++) begin
      run_test(VECS[k].con, VECS[k].inj, VECS[k].idx, VECS[k].bitn, VECS[k].val, VECS[k].sum_ok, lat);
      chk("R1 done seen", test_done, 1);
      chk("R2 R3 R4 R5 fault code", fault_code, VECS[k].code);
      chk("R6 discrete", fault_discrete, VECS[k].disc);
      chk("R7 console", console_mode, VECS[k].cmode);
      chk("R9 run", exec_run, VECS[k].run);
      chk("R8 blocked", exec_blocked, VECS[k].blk);
    end

    // R1 latency and pulse width; R9 direct start
    run_test(1'b0, 1'b0, 3'd0, 4'd0, 1'b0, 1'b1, lat);
    chk("R1 latency", lat, 4 * (NREG + 2) + DEPTH + 1);
    chk("R9 strobe", start_strobe, 1);
    chk("R9 start addr", start_addr, RVEC);
    chk("R9 timers", {timer_b_en, timer_a_en}, 2'b11);
    @(negedge clk);
    chk("R1 done one cycle", test_done, 0);
    chk("R9 strobe one cycle", start_strobe, 0);
    // R12 commands outside console
    send(1'b1, 2'd0, 1'b1, 16'hBEEF);
    chk("R12 addr kept", start_addr, RVEC);
    chk("R12 timers kept", {timer_b_en, timer_a_en}, 2'b11);
    chk("R12 no strobe", start_strobe, 0);
    chk("R12 no console", console_mode, 0);

    // R10 continue arguments
    for (int a = 0; a < 4; a++) begin
      run_test(1'b1, 1'b0, 3'd0, 4'd0, 1'b0, 1'b1, lat);
      chk("R7 console entered", console_mode, 1);
      @(negedge clk);
      send(1'b1, 2'(a), 1'b0, 16'h0);
      chk("R10 console left", console_mode, 0);
      chk("R10 running", exec_run, 1);
      chk("R10 timer A", timer_a_en, a[0]);
      chk("R10 timer B", timer_b_en, a[1]);
      chk("R10 no strobe", start_strobe, 0);
    end

    // R11 run with continue in the same cycle
    run_test(1'b1, 1'b0, 3'd0, 4'd0, 1'b0, 1'b0, lat);
    @(negedge clk);
    send(1'b1, 2'd1, 1'b1, 16'h1234);
    chk("R11 start addr", start_addr, 16'h1234);
    chk("R11 strobe", start_strobe, 1);
    chk("R11 timers", {timer_b_en, timer_a_en}, 2'b11);
    chk("R11 running", {console_mode, exec_run}, 2'b01);
    @(negedge clk);
    chk("R11 strobe one cycle", start_strobe, 0);
    chk("R6 code held", fault_code, 4'h6);

    // R8 critical failure ignores console commands
    run_test(1'b1, 1'b1, 3'd1, 4'd0, 1'b1, 1'b1, lat);
    @(negedge clk);
    send(1'b1, 2'd3, 1'b0, 16'h0);
    send(1'b0, 2'd0, 1'b1, 16'h2222);
    chk("R8 still console", console_mode, 1);
    chk("R8 no run", exec_run, 0);
    chk("R8 timers off", {timer_b_en, timer_a_en}, 2'b00);
    chk("R8 addr untouched", start_addr, 16'h0);
    chk("R6 code held", fault_code, 4'h5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule